// File: doc/BRIEF.md
# Morse Code Keyer with Programmable Element Timing

This block turns packed character codes into on/off keying on one output line. A character is a 10-bit word. It holds up to seven element bits and a three-bit element count. The block plays the elements in order, with the key held high for each mark and low for every gap.

Mark and gap lengths are set by three 32-bit cycle counts, one each for the short mark, the long mark and the unit space. Each element reloads its own count, so the long-to-short ratio is free to take any value rather than being tied to a fixed multiple. A valid/ready handshake hands over one character at a time. A word-gap flag, taken with the character, stretches the silence that follows it.

Top module: `morse_keyer`

## Requirements
- R1: A character word carries its element bits in [9:3] and its element count (0 to 7) in [2:0]. The elements play starting at bit 9 and moving down, and there is exactly one mark per counted element. Bit value 1 is a long mark (dash) and 0 is a short mark (dot).
- R2: `key_o` is high only while a mark plays. It is low during every gap and while the block is idle.
- R3: A dot mark lasts `dot_cycles_i` clock cycles and a dash mark lasts `dash_cycles_i` clock cycles.
- R4: One space of `space_cycles_i` cycles follows every mark except the last one of the character.
- R5: After the last mark, the key stays low for 4 × `space_cycles_i` cycles: one element space plus a three-unit character gap.
- R6: When `word_gap_i` is high at acceptance, the silence after the last mark is instead 8 × `space_cycles_i` cycles: one element space plus a seven-unit word gap.
- R7: A duration input of zero acts as one cycle.
- R8: A duration input is sampled only when a mark, space or gap unit starts. A change in the middle of an element does not alter that element's length.
- R9: `char_ready_o` is high only while idle. A character is accepted on a clock edge where `char_valid_i` and `char_ready_o` are both high, and its first mark starts in the next cycle.
- R10: `busy_o` goes high in the cycle after acceptance and stays high until the final gap ends. At that point `char_ready_o` returns high.
- R11: A character with element count 0 produces no mark. It only holds the key low for the gap (3 or 7 units of `space_cycles_i`).
- R12: Asserting `rst_ni` low at any time forces the idle state at once: key low, busy low, ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_valid_i | input | 1 | A character word is offered |
| char_pattern_i | input | 10 | Element bits [9:3], element count [2:0] |
| word_gap_i | input | 1 | Use a word gap after this character |
| dot_cycles_i | input | 32 | Short-mark length in cycles |
| dash_cycles_i | input | 32 | Long-mark length in cycles |
| space_cycles_i | input | 32 | Unit space length in cycles |
| char_ready_o | output | 1 | Block can accept a character |
| key_o | output | 1 | Keying output, high during marks |
| busy_o | output | 1 | A character is being played |

## Verification
The assertions assume that `char_pattern_i` and `word_gap_i` are valid on any edge where `char_valid_i` is high. They also assume reset is released only between clock edges. The duration inputs are taken as arbitrary, since the block samples them only at boundaries. The stimulus changes every input on the falling clock edge. It drops `char_valid_i` right after acceptance, and it changes a duration in mid-element only in the one test aimed at boundary sampling.

// File: rtl/morse_pkg.sv
package morse_pkg;
  localparam int PAT_W  = 10;
  localparam int LEN_W  = 3;
  localparam int BITS_W = PAT_W - LEN_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MARK  = 2'd1,
    ST_SPACE = 2'd2,
    ST_GAP   = 2'd3
  } key_state_e;
endpackage

// File: rtl/morse_dur_counter.sv
module morse_dur_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] value_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  // load value-1 so that the element lasts exactly value cycles; zero acts as one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= (value_i == '0) ? '0 : value_i - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/morse_elem_shifter.sv
module morse_elem_shifter #(
  parameter int BITS_W = 7,
  parameter int LEN_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BITS_W-1:0] bits_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              advance_i,
  output logic              head_o,
  output logic [LEN_W-1:0]  rem_o
);
  logic [BITS_W-1:0] bits_q;
  logic [LEN_W-1:0]  rem_q;

  // load consumes the first element at once; advance consumes one more
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      bits_q <= {bits_i[BITS_W-2:0], 1'b0};
      rem_q  <= (len_i == '0) ? '0 : len_i - LEN_W'(1);
    end else if (advance_i) begin
      bits_q <= {bits_q[BITS_W-2:0], 1'b0};
      rem_q  <= rem_q - LEN_W'(1);
    end
  end

  assign head_o = bits_q[BITS_W-1];
  assign rem_o  = rem_q;
endmodule

// File: rtl/morse_gap_units.sv
module morse_gap_units #(
  parameter int UNIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [UNIT_W-1:0] units_i,
  input  logic              step_i,
  output logic              last_o
);
  logic [UNIT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (load_i) begin
      left_q <= units_i;
    end else if (step_i && left_q != '0) begin
      left_q <= left_q - UNIT_W'(1);
    end
  end

  assign last_o = (left_q <= UNIT_W'(1));
endmodule

// File: rtl/morse_keyer.sv
module morse_keyer
  import morse_pkg::*;
#(
  parameter int CNT_W          = 32,
  parameter int CHAR_GAP_UNITS = 3,
  parameter int WORD_GAP_UNITS = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               char_valid_i,
  input  logic [PAT_W-1:0]   char_pattern_i,
  input  logic               word_gap_i,
  input  logic [CNT_W-1:0]   dot_cycles_i,
  input  logic [CNT_W-1:0]   dash_cycles_i,
  input  logic [CNT_W-1:0]   space_cycles_i,
  output logic               char_ready_o,
  output logic               key_o,
  output logic               busy_o
);
  localparam int MAX_UNITS = (WORD_GAP_UNITS > CHAR_GAP_UNITS) ? WORD_GAP_UNITS : CHAR_GAP_UNITS;
  localparam int UNIT_W    = $clog2(MAX_UNITS + 1);
  localparam logic [UNIT_W-1:0] CHAR_U = UNIT_W'(CHAR_GAP_UNITS);
  localparam logic [UNIT_W-1:0] WORD_U = UNIT_W'(WORD_GAP_UNITS);

  key_state_e state_q, state_d;
  logic              accept;
  logic [LEN_W-1:0]  pat_len;
  logic [BITS_W-1:0] pat_bits;
  logic              word_q;
  logic              cnt_load, cnt_done;
  logic [CNT_W-1:0]  cnt_val;
  logic              sh_load, sh_adv, sh_head;
  logic [LEN_W-1:0]  sh_rem;
  logic              gap_load, gap_step, gap_last;
  logic [UNIT_W-1:0] gap_units;

  assign char_ready_o = (state_q == ST_IDLE);
  assign accept       = char_valid_i & char_ready_o;
  assign pat_len      = char_pattern_i[LEN_W-1:0];
  assign pat_bits     = char_pattern_i[PAT_W-1:LEN_W];
  assign gap_units    = (state_q == ST_IDLE) ? (word_gap_i ? WORD_U : CHAR_U)
                                             : (word_q     ? WORD_U : CHAR_U);

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = space_cycles_i;
    sh_load  = 1'b0;
    sh_adv   = 1'b0;
    gap_load = 1'b0;
    gap_step = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          cnt_load = 1'b1;
          if (pat_len != '0) begin
            state_d = ST_MARK;
            sh_load = 1'b1;
            cnt_val = pat_bits[BITS_W-1] ? dash_cycles_i : dot_cycles_i;
          end else begin
            state_d  = ST_GAP;
            gap_load = 1'b1;
          end
        end
      end
      ST_MARK: begin
        if (cnt_done) begin
          state_d  = ST_SPACE;
          cnt_load = 1'b1;
        end
      end
      ST_SPACE: begin
        if (cnt_done) begin
          cnt_load = 1'b1;
          if (sh_rem != '0) begin
            state_d = ST_MARK;
            sh_adv  = 1'b1;
            cnt_val = sh_head ? dash_cycles_i : dot_cycles_i;
          end else begin
            state_d  = ST_GAP;
            gap_load = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (cnt_done) begin
          if (gap_last) begin
            state_d = ST_IDLE;
          end else begin
            cnt_load = 1'b1;
            gap_step = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      word_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) word_q <= word_gap_i;
    end
  end

  morse_dur_counter #(.CNT_W(CNT_W)) i_dur (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cnt_load),
    .value_i (cnt_val),
    .done_o  (cnt_done)
  );

  morse_elem_shifter #(.BITS_W(BITS_W), .LEN_W(LEN_W)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (sh_load),
    .bits_i    (pat_bits),
    .len_i     (pat_len),
    .advance_i (sh_adv),
    .head_o    (sh_head),
    .rem_o     (sh_rem)
  );

  morse_gap_units #(.UNIT_W(UNIT_W)) i_gap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (gap_load),
    .units_i (gap_units),
    .step_i  (gap_step),
    .last_o  (gap_last)
  );

  assign key_o  = (state_q == ST_MARK);
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/morse_keyer_chk.sv
module morse_keyer_chk #(
  parameter int PAT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             char_valid_i,
  input logic [PAT_W-1:0] char_pattern_i,
  input logic             char_ready_o,
  input logic             key_o,
  input logic             busy_o
);
  logic take;
  assign take = char_valid_i & char_ready_o;

  p_key_implies_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_o |-> busy_o);

  p_accept_marks_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && char_pattern_i[2:0] != 3'd0) |=> key_o);

  p_len0_silent_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && char_pattern_i[2:0] == 3'd0) |=> (!key_o && busy_o));

  p_accept_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (busy_o && !char_ready_o));

  p_busy_rise_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(take));

  p_busy_fall_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(!key_o));
endmodule

bind morse_keyer morse_keyer_chk #(.PAT_W(10)) i_morse_keyer_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .char_valid_i   (char_valid_i),
  .char_pattern_i (char_pattern_i),
  .char_ready_o   (char_ready_o),
  .key_o          (key_o),
  .busy_o         (busy_o)
);

// File: tb/test_morse_keyer.sv
module test_morse_keyer;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [9:0]  pat;
    logic        word;
    logic [15:0] dot;
    logic [15:0] dash;
    logic [15:0] spc;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{10'b0000000_001, 1'b0, 16'd2, 16'd5, 16'd3},  // single dot
    '{10'b0100000_010, 1'b0, 16'd3, 16'd7, 16'd2},  // dot dash
    '{10'b1010000_011, 1'b1, 16'd2, 16'd4, 16'd1},  // dash dot dash, word gap
    '{10'b1010110_111, 1'b0, 16'd1, 16'd3, 16'd2},  // seven elements
    '{10'b1111000_100, 1'b1, 16'd2, 16'd6, 16'd2},  // four dashes, word gap
    '{10'b0000000_000, 1'b0, 16'd2, 16'd2, 16'd4},  // empty character (R11)
    '{10'b1000000_010, 1'b0, 16'd0, 16'd0, 16'd0}   // zero counts (R7)
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        char_valid = 1'b0;
  logic [9:0]  char_pattern = '0;
  logic        word_gap = 1'b0;
  logic [31:0] dot_cycles = 32'd1;
  logic [31:0] dash_cycles = 32'd1;
  logic [31:0] space_cycles = 32'd1;
  logic        char_ready, key, busy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  morse_keyer i_morse_keyer (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .char_valid_i   (char_valid),
    .char_pattern_i (char_pattern),
    .word_gap_i     (word_gap),
    .dot_cycles_i   (dot_cycles),
    .dash_cycles_i  (dash_cycles),
    .space_cycles_i (space_cycles),
    .char_ready_o   (char_ready),
    .key_o          (key),
    .busy_o         (busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int at_least1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  // Play one character and compare the key run lengths to the requirement values.
  // dash_late: dash length expected for elements after the first (R8 test).
  task automatic run_char(input logic [9:0] pat, input logic w, input int d, input int da,
                          input int s, input int chg_cycle, input int chg_val,
                          input int dash_late);
    int runs [32];
    int exp_r [32];
    int nruns, exp_n, run_len, cyc, n, units;
    logic cur, first_lvl;
    @(negedge clk);
    dot_cycles = d; dash_cycles = da; space_cycles = s;
    char_pattern = pat; word_gap = w; char_valid = 1'b1;
    chk(char_ready == 1'b1, "R9 ready before accept", int'(char_ready), 1);
    @(posedge clk);
    @(negedge clk);
    char_valid = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
    chk(char_ready == 1'b0, "R9 ready low while busy", int'(char_ready), 0);
    nruns = 0; run_len = 0; cyc = 0;
    cur = key; first_lvl = key;
    while (busy && cyc < 5000) begin
      if (cyc == chg_cycle) dash_cycles = chg_val;
      if (key == cur) run_len++;
      else begin
        if (nruns < 32) runs[nruns] = run_len;
        nruns++;
        cur = key; run_len = 1;
      end
      @(negedge clk);
      cyc++;
    end
    if (nruns < 32) runs[nruns] = run_len;
    nruns++;
    // expected from requirements
    n = int'(pat[2:0]);
    units = w ? 7 : 3;
    exp_n = 0;
    if (n == 0) begin
      exp_r[0] = units * at_least1(s);
      exp_n = 1;
    end else begin
      for (int i = 0; i < n; i++) begin
        if (pat[9-i]) exp_r[exp_n] = (i == 0) ? at_least1(da) : at_least1(dash_late);
        else          exp_r[exp_n] = at_least1(d);
        exp_n++;
        exp_r[exp_n] = at_least1(s);
        exp_n++;
      end
      exp_r[exp_n-1] = exp_r[exp_n-1] + units * at_least1(s);
    end
    chk(first_lvl == (n != 0), "R1/R11 first level", int'(first_lvl), int'(n != 0));
    chk(nruns == exp_n, "R1 run count", nruns, exp_n);
    if (nruns == exp_n) begin
      for (int i = 0; i < exp_n; i++) begin
        if (n == 0)              chk(runs[i] == exp_r[i], "R11 empty gap", runs[i], exp_r[i]);
        else if (i == exp_n - 1) chk(runs[i] == exp_r[i], w ? "R6 word gap" : "R5 char gap", runs[i], exp_r[i]);
        else if (i % 2 == 0)     chk(runs[i] == exp_r[i], "R3/R7 mark", runs[i], exp_r[i]);
        else                     chk(runs[i] == exp_r[i], "R4 space", runs[i], exp_r[i]);
      end
    end
    chk(key == 1'b0, "R2 key low after char", int'(key), 0);
    chk(char_ready == 1'b1, "R10 ready after char", int'(char_ready), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    if (!done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(key == 1'b0, "R12 reset key", int'(key), 0);
    chk(busy == 1'b0, "R12 reset busy", int'(busy), 0);
    chk(char_ready == 1'b1, "R12 reset ready", int'(char_ready), 1);
    rst_ni = 1'b1;
    // R2 idle with nothing offered
    repeat (5) @(negedge clk);
    chk(key == 1'b0 && busy == 1'b0, "R2 idle quiet", int'({key, busy}), 0);

    for (int v = 0; v < NVEC; v++) begin
      run_char(VECS[v].pat, VECS[v].word, int'(VECS[v].dot), int'(VECS[v].dash),
               int'(VECS[v].spc), -1, 0, int'(VECS[v].dash));
    end

    // R8: dash count changed in the middle of the first dash
    run_char(10'b1100000_010, 1'b0, 2, 4, 2, 1, 6, 6);

    // R12: reset in mid-playback
    @(negedge clk);
    dot_cycles = 5; dash_cycles = 9; space_cycles = 3;
    char_pattern = 10'b1000000_001; word_gap = 1'b0; char_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    char_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(key == 1'b1, "R3 dash in progress", int'(key), 1);
    rst_ni = 1'b0;
    #1;
    chk(key == 1'b0, "R12 async key", int'(key), 0);
    chk(busy == 1'b0, "R12 async busy", int'(busy), 0);
    chk(char_ready == 1'b1, "R12 async ready", int'(char_ready), 1);
    @(negedge clk);
    rst_ni = 1'b1;
    run_char(10'b0000000_001, 1'b0, 1, 2, 1, -1, 0, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule